// File: doc/BRIEF.md
# Paired-Single Lane Permute Unit

This block carries out the data-movement subset of the paired-single floating-point instructions on 64-bit FPU register values. A paired value holds two single-precision lanes: the upper lane in bits 63:32 and the lower lane in bits 31:0. The block decodes a 32-bit instruction word and takes three register values (fs, ft and the current destination fd), a general-register alignment value, an eight-bit condition-code vector, an endianness flag and the privilege state. From these it forms a 64-bit result. Lanes are only moved, never computed on: no rounding, no NaN rewriting, no arithmetic.

The issue logic presents an instruction with a one-cycle valid strobe. One clock later the registered result appears together with a write-enable for the register file, or with a reserved-instruction exception flag that the core turns into a trap. A further flag marks the alignment case whose architectural result is unpredictable. In that case the block returns fs, so its output is still well defined.

Top module: `ps_permute_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, result_o is zero and wr_en_o, ri_exc_o and unpred_o are low.
- R2: With insn[31:26]=010001 and insn[25:21]=10110, function codes insn[5:0] 101100, 101101, 101110 and 101111 produce {fs.lo, ft.lo}, {fs.lo, ft.hi}, {fs.hi, ft.lo} and {fs.hi, ft.hi}. Here {a, b} puts a in bits 63:32 and b in bits 31:0, .hi means bits 63:32 and .lo means bits 31:0.
- R3: With insn[31:26]=010001, insn[25:21]=10000 and function 100110, each source is taken as a single in bits 31:0, and the result is {fs.lo, ft.lo}.
- R4: With the paired format (10110), function 101000 returns {32'h0, fs.lo} and function 100000 returns {32'h0, fs.hi}.
- R5: Align is insn[31:26]=010011 with function 011110. If align_i[2] is 0 the result is fs. If align_i[1:0] is nonzero the result is fs and unpred_o is high with wr_en_o. unpred_o is low in every other case.
- R6: For align with align_i[2:0]=100, the result is {fs.lo, ft.hi} when big_endian_i is 1 and {ft.lo, fs.hi} when it is 0.
- R7: The paired conditional move is COP1, format 10110, function 010001, with cc=insn[20:18], insn[17]=0 and tf=insn[16]. The upper lane is fs.hi when cc_i[cc+1]==tf, and fd.hi otherwise. The lower lane is fs.lo when cc_i[cc]==tf, and fd.lo otherwise. If cc=7 or insn[17]=1, the instruction is reserved.
- R8: When user_mode_i is 1 and both ux_en_i and px_en_i are 0, every instruction this block handles raises ri_exc_o and gives no write.
- R9: Any opcode, format or function combination not listed in R2 to R7 raises ri_exc_o with wr_en_o low. On every exception result_o is zero, and wr_en_o and ri_exc_o are never high together.
- R10: Outputs are registered exactly one cycle after a valid_i cycle. After a cycle with valid_i low, wr_en_o, ri_exc_o and unpred_o are low and result_o keeps its value.
- R11: Lane bits are copied exactly, including NaN and denormal patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word |
| fs_i | input | 64 | First source register value |
| ft_i | input | 64 | Second source register value |
| fd_i | input | 64 | Current destination register value |
| align_i | input | GPR_W (64) | General register holding the byte alignment |
| cc_i | input | 8 | FP condition-code bits |
| big_endian_i | input | 1 | 1 selects big-endian alignment |
| user_mode_i | input | 1 | Core is in user mode |
| ux_en_i | input | 1 | 64-bit user operation enable |
| px_en_i | input | 1 | Paired user operation enable |
| result_o | output | 64 | Registered result |
| wr_en_o | output | 1 | Destination write enable |
| ri_exc_o | output | 1 | Reserved-instruction exception |
| unpred_o | output | 1 | Unpredictable-alignment marker |

## Verification
The bench checks each of the four pack function codes against distinct lane patterns, so swapping the upper and lower selectors shows up as a wrong half. It drives align with both endianness settings and with misaligned values 1 and 6. A design that ignored bits 1:0 would leave unpred_o low, and one that reversed the endian rule would return the lanes the wrong way round. Conditional moves are run with a condition vector in which cc and cc+1 differ, in both the true and the false sense, and with cc=7. A design that moved the whole value, or indexed the wrong bit, would replace or keep the wrong lane. The privilege gate is exercised with each enable alone. An idle cycle after an operation shows whether the result holds and the strobes drop.

// File: rtl/ps_perm_pkg.sv
package ps_perm_pkg;

    localparam int LANE_W   = 32;
    localparam int VAL_W    = 2 * LANE_W;
    localparam int INSN_W   = 32;
    localparam int CC_W     = 8;
    localparam int CC_IDX_W = $clog2(CC_W);

    localparam logic [5:0] OPC_COP1  = 6'b010001;
    localparam logic [5:0] OPC_COP1X = 6'b010011;
    localparam logic [4:0] FMT_PAIR  = 5'b10110;
    localparam logic [4:0] FMT_SGL   = 5'b10000;

    localparam logic [5:0] FN_PACK_LL = 6'b101100;
    localparam logic [5:0] FN_PACK_LU = 6'b101101;
    localparam logic [5:0] FN_PACK_UL = 6'b101110;
    localparam logic [5:0] FN_PACK_UU = 6'b101111;
    localparam logic [5:0] FN_JOIN_SS = 6'b100110;
    localparam logic [5:0] FN_TAKE_LO = 6'b101000;
    localparam logic [5:0] FN_TAKE_HI = 6'b100000;
    localparam logic [5:0] FN_CMOVE   = 6'b010001;
    localparam logic [5:0] FN_ALIGN   = 6'b011110;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PACK,
        OP_JOIN,
        OP_TAKE_LO,
        OP_TAKE_HI,
        OP_ALIGN,
        OP_CMOVE
    } op_e;

    typedef struct packed {
        op_e                 op;
        logic                a_hi;
        logic                b_hi;
        logic [CC_IDX_W-1:0] cc_idx;
        logic                tf;
        logic                illegal;
    } dec_t;

    function automatic logic [LANE_W-1:0] lane_hi(input logic [VAL_W-1:0] v);
        return v[VAL_W-1:LANE_W];
    endfunction

    function automatic logic [LANE_W-1:0] lane_lo(input logic [VAL_W-1:0] v);
        return v[LANE_W-1:0];
    endfunction

    function automatic logic [VAL_W-1:0] join_lanes(input logic [LANE_W-1:0] up,
                                                    input logic [LANE_W-1:0] dn);
        return {up, dn};
    endfunction

endpackage

// File: rtl/ps_perm_decode.sv
module ps_perm_decode
    import ps_perm_pkg::*;
(
    input  logic [5:0]          opc_i,
    input  logic [4:0]          fmt_i,
    input  logic [4:0]          sel_i,
    input  logic [5:0]          func_i,
    output dec_t                dec_o
);

    logic [CC_IDX_W-1:0] cc_field;
    logic                pad_bit;
    logic                tf_bit;

    assign cc_field = sel_i[4:2];
    assign pad_bit  = sel_i[1];
    assign tf_bit   = sel_i[0];

    always_comb begin
        dec_o         = '0;
        dec_o.op      = OP_NONE;
        dec_o.illegal = 1'b1;
        if (opc_i == OPC_COP1) begin
            if (fmt_i == FMT_PAIR) begin
                unique case (func_i)
                    FN_PACK_LL, FN_PACK_LU, FN_PACK_UL, FN_PACK_UU: begin
                        dec_o.op      = OP_PACK;
                        dec_o.a_hi    = func_i[1];
                        dec_o.b_hi    = func_i[0];
                        dec_o.illegal = 1'b0;
                    end
                    FN_TAKE_LO: begin
                        dec_o.op      = OP_TAKE_LO;
                        dec_o.illegal = 1'b0;
                    end
                    FN_TAKE_HI: begin
                        dec_o.op      = OP_TAKE_HI;
                        dec_o.illegal = 1'b0;
                    end
                    FN_CMOVE: begin
                        if (!pad_bit && (cc_field != {CC_IDX_W{1'b1}})) begin
                            dec_o.op      = OP_CMOVE;
                            dec_o.cc_idx  = cc_field;
                            dec_o.tf      = tf_bit;
                            dec_o.illegal = 1'b0;
                        end
                    end
                    default: begin
                        dec_o.op      = OP_NONE;
                        dec_o.illegal = 1'b1;
                    end
                endcase
            end else if (fmt_i == FMT_SGL && func_i == FN_JOIN_SS) begin
                dec_o.op      = OP_JOIN;
                dec_o.illegal = 1'b0;
            end
        end else if (opc_i == OPC_COP1X && func_i == FN_ALIGN) begin
            dec_o.op      = OP_ALIGN;
            dec_o.illegal = 1'b0;
        end
    end

endmodule

// File: rtl/ps_lane_select.sv
module ps_lane_select
    import ps_perm_pkg::*;
(
    input  dec_t              dec_i,
    input  logic [VAL_W-1:0]  fs_i,
    input  logic [VAL_W-1:0]  ft_i,
    input  logic [VAL_W-1:0]  fd_i,
    input  logic [2:0]        shift_i,
    input  logic [CC_W-1:0]   cc_i,
    input  logic              big_endian_i,
    output logic [VAL_W-1:0]  res_o,
    output logic              unpred_o
);

    logic [LANE_W-1:0] pick_a;
    logic [LANE_W-1:0] pick_b;
    logic [VAL_W-1:0]  align_val;
    logic [VAL_W-1:0]  cmove_val;
    logic              misaligned;

    assign pick_a = dec_i.a_hi ? lane_hi(fs_i) : lane_lo(fs_i);
    assign pick_b = dec_i.b_hi ? lane_hi(ft_i) : lane_lo(ft_i);

    assign misaligned = |shift_i[1:0];

    always_comb begin
        if (misaligned || !shift_i[2]) begin
            align_val = fs_i;
        end else if (big_endian_i) begin
            align_val = join_lanes(lane_lo(fs_i), lane_hi(ft_i));
        end else begin
            align_val = join_lanes(lane_lo(ft_i), lane_hi(fs_i));
        end
    end

    // Lane 0 is the lower half and follows cc; lane 1 follows cc+1.
    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic [CC_IDX_W:0] pos;
        logic              take;
        assign pos  = {1'b0, dec_i.cc_idx} + (CC_IDX_W+1)'(l);
        assign take = (pos < (CC_IDX_W+1)'(CC_W)) ?
                      (cc_i[pos[CC_IDX_W-1:0]] == dec_i.tf) : 1'b0;
        assign cmove_val[l*LANE_W +: LANE_W] = take ? fs_i[l*LANE_W +: LANE_W]
                                                    : fd_i[l*LANE_W +: LANE_W];
    end

    always_comb begin
        res_o    = '0;
        unpred_o = 1'b0;
        unique case (dec_i.op)
            OP_PACK:    res_o = join_lanes(pick_a, pick_b);
            OP_JOIN:    res_o = join_lanes(lane_lo(fs_i), lane_lo(ft_i));
            OP_TAKE_LO: res_o = join_lanes('0, lane_lo(fs_i));
            OP_TAKE_HI: res_o = join_lanes('0, lane_hi(fs_i));
            OP_ALIGN: begin
                res_o    = align_val;
                unpred_o = misaligned;
            end
            OP_CMOVE:   res_o = cmove_val;
            default:    res_o = '0;
        endcase
    end

endmodule

// File: rtl/ps_result_reg.sv
module ps_result_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_i,
    input  logic         exc_i,
    input  logic         unpred_i,
    input  logic [W-1:0] res_i,
    output logic [W-1:0] res_o,
    output logic         wr_en_o,
    output logic         exc_o,
    output logic         unpred_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o    <= '0;
            wr_en_o  <= 1'b0;
            exc_o    <= 1'b0;
            unpred_o <= 1'b0;
        end else begin
            wr_en_o  <= valid_i && !exc_i;
            exc_o    <= valid_i && exc_i;
            unpred_o <= valid_i && !exc_i && unpred_i;
            if (valid_i) begin
                res_o <= exc_i ? '0 : res_i;
            end
        end
    end

endmodule

// File: rtl/ps_permute_unit.sv
module ps_permute_unit
    import ps_perm_pkg::*;
#(
    parameter int GPR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [VAL_W-1:0]  fs_i,
    input  logic [VAL_W-1:0]  ft_i,
    input  logic [VAL_W-1:0]  fd_i,
    input  logic [GPR_W-1:0]  align_i,
    input  logic [CC_W-1:0]   cc_i,
    input  logic              big_endian_i,
    input  logic              user_mode_i,
    input  logic              ux_en_i,
    input  logic              px_en_i,
    output logic [VAL_W-1:0]  result_o,
    output logic              wr_en_o,
    output logic              ri_exc_o,
    output logic              unpred_o
);

    dec_t             dec;
    logic             priv_block;
    logic             exc;
    logic [VAL_W-1:0] res_c;
    logic             unpred_c;
    logic             unused_bits;

    // Register numbers and high alignment bits are resolved outside this block.
    assign unused_bits = ^{insn_i[15:6], align_i[GPR_W-1:3]};

    ps_perm_decode u_dec (
        .opc_i  (insn_i[31:26]),
        .fmt_i  (insn_i[25:21]),
        .sel_i  (insn_i[20:16]),
        .func_i (insn_i[5:0]),
        .dec_o  (dec)
    );

    assign priv_block = user_mode_i && !ux_en_i && !px_en_i;
    assign exc        = dec.illegal || priv_block;

    ps_lane_select u_sel (
        .dec_i        (dec),
        .fs_i         (fs_i),
        .ft_i         (ft_i),
        .fd_i         (fd_i),
        .shift_i      (align_i[2:0]),
        .cc_i         (cc_i),
        .big_endian_i (big_endian_i),
        .res_o        (res_c),
        .unpred_o     (unpred_c)
    );

    ps_result_reg #(.W(VAL_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (valid_i),
        .exc_i    (exc),
        .unpred_i (unpred_c),
        .res_i    (res_c),
        .res_o    (result_o),
        .wr_en_o  (wr_en_o),
        .exc_o    (ri_exc_o),
        .unpred_o (unpred_o)
    );

endmodule

// File: rtl/ps_perm_checker.sv
module ps_perm_checker (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic [31:0] insn_i,
    input logic [63:0] fs_i,
    input logic [63:0] ft_i,
    input logic        user_mode_i,
    input logic        ux_en_i,
    input logic        px_en_i,
    input logic [63:0] result_o,
    input logic        wr_en_o,
    input logic        ri_exc_o,
    input logic        unpred_o
);

    // R9: a write and a trap never coincide
    assert_write_trap_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_o && ri_exc_o));

    // R9: trapped instructions leave a zero result
    assert_trap_zero_R9: assert property (@(posedge clk) disable iff (rst)
        ri_exc_o |-> (result_o == 64'h0));

    // R10: an idle cycle produces no strobes and holds the result
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!wr_en_o && !ri_exc_o && !unpred_o && $stable(result_o)));

    // R8: privilege gate
    assert_priv_trap_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && user_mode_i && !ux_en_i && !px_en_i) |=> (ri_exc_o && !wr_en_o));

    // R5: unpredictable marker only on a performed write
    assert_unpred_write_R5: assert property (@(posedge clk) disable iff (rst)
        unpred_o |-> wr_en_o);

    // R2: upper-upper pack
    assert_pack_uu_R2: assert property (@(posedge clk) disable iff (rst)
        (valid_i && insn_i[31:26] == 6'b010001 && insn_i[25:21] == 5'b10110 &&
         insn_i[5:0] == 6'b101111 && !(user_mode_i && !ux_en_i && !px_en_i))
        |=> (wr_en_o && result_o == {$past(fs_i[63:32]), $past(ft_i[63:32])}));

endmodule

bind ps_permute_unit ps_perm_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (valid_i),
    .insn_i      (insn_i),
    .fs_i        (fs_i),
    .ft_i        (ft_i),
    .user_mode_i (user_mode_i),
    .ux_en_i     (ux_en_i),
    .px_en_i     (px_en_i),
    .result_o    (result_o),
    .wr_en_o     (wr_en_o),
    .ri_exc_o    (ri_exc_o),
    .unpred_o    (unpred_o)
);

// File: tb/tb_ps_permute_unit.sv
`timescale 1ns/1ps
module tb_ps_permute_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [31:0] insn_i;
    logic [63:0] fs_i, ft_i, fd_i, align_i;
    logic [7:0]  cc_i;
    logic        big_endian_i, user_mode_i, ux_en_i, px_en_i;
    logic [63:0] result_o;
    logic        wr_en_o, ri_exc_o, unpred_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ps_permute_unit dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i),
        .fs_i(fs_i), .ft_i(ft_i), .fd_i(fd_i), .align_i(align_i),
        .cc_i(cc_i), .big_endian_i(big_endian_i), .user_mode_i(user_mode_i),
        .ux_en_i(ux_en_i), .px_en_i(px_en_i), .result_o(result_o),
        .wr_en_o(wr_en_o), .ri_exc_o(ri_exc_o), .unpred_o(unpred_o)
    );

    function automatic logic [31:0] mk_ps(input logic [5:0] fn);
        return {6'b010001, 5'b10110, 5'd2, 5'd3, 5'd4, fn};
    endfunction
    function automatic logic [31:0] mk_sgl(input logic [5:0] fn);
        return {6'b010001, 5'b10000, 5'd2, 5'd3, 5'd4, fn};
    endfunction
    function automatic logic [31:0] mk_aln();
        return {6'b010011, 5'd7, 5'd2, 5'd3, 5'd4, 6'b011110};
    endfunction
    function automatic logic [31:0] mk_mov(input logic [2:0] cc, input logic tf);
        return {6'b010001, 5'b10110, cc, 1'b0, tf, 5'd3, 5'd4, 6'b010001};
    endfunction

    typedef struct packed {
        logic [31:0] insn;
        logic [63:0] fs;
        logic [63:0] ft;
        logic [63:0] fd;
        logic [2:0]  al;
        logic [7:0]  cc;
        logic        be;
        logic [63:0] exp;
        logic        we;
    } vec_t;

    localparam logic [63:0] A = 64'h11112222_33334444;
    localparam logic [63:0] B = 64'h55556666_77778888;
    localparam logic [63:0] D = 64'h9999AAAA_BBBBCCCC;
    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{mk_ps(6'b101100), A, B, D, 3'd0, 8'h00, 1'b0, 64'h33334444_77778888, 1'b1}, // R2 lo/lo
        '{mk_ps(6'b101101), A, B, D, 3'd0, 8'h00, 1'b0, 64'h33334444_55556666, 1'b1}, // R2 lo/hi
        '{mk_ps(6'b101110), A, B, D, 3'd0, 8'h00, 1'b0, 64'h11112222_77778888, 1'b1}, // R2 hi/lo
        '{mk_ps(6'b101111), A, B, D, 3'd0, 8'h00, 1'b0, 64'h11112222_55556666, 1'b1}, // R2 hi/hi
        '{mk_sgl(6'b100110), A, B, D, 3'd0, 8'h00, 1'b0, 64'h33334444_77778888, 1'b1}, // R3
        '{mk_ps(6'b101000), A, B, D, 3'd0, 8'h00, 1'b0, 64'h00000000_33334444, 1'b1}, // R4 lower
        '{mk_ps(6'b100000), A, B, D, 3'd0, 8'h00, 1'b0, 64'h00000000_11112222, 1'b1}, // R4 upper
        '{mk_aln(),         A, B, D, 3'd0, 8'h00, 1'b1, A,                     1'b1}, // R5 bit2 clear
        '{mk_aln(),         A, B, D, 3'd4, 8'h00, 1'b1, 64'h33334444_55556666, 1'b1}, // R6 big
        '{mk_aln(),         A, B, D, 3'd4, 8'h00, 1'b0, 64'h77778888_11112222, 1'b1}, // R6 little
        '{mk_mov(3'd2, 1'b1), A, B, D, 3'd0, 8'h04, 1'b0, 64'h9999AAAA_33334444, 1'b1}, // R7 true
        '{mk_mov(3'd2, 1'b0), A, B, D, 3'd0, 8'h04, 1'b0, 64'h11112222_BBBBCCCC, 1'b1}, // R7 false
        '{mk_mov(3'd7, 1'b1), A, B, D, 3'd0, 8'hFF, 1'b0, 64'h0,               1'b0}, // R7 cc=7
        '{mk_ps(6'b000000), A, B, D, 3'd0, 8'h00, 1'b0, 64'h0,                 1'b0}, // R9 func
        '{64'h0 | 32'h0000_002C, A, B, D, 3'd0, 8'h00, 1'b0, 64'h0,            1'b0}, // R9 opcode
        '{mk_ps(6'b101110), 64'hFFFFFFFF_7FBFFFFF, 64'h80000000_00000001, D, 3'd0, 8'h00, 1'b0,
          64'hFFFFFFFF_00000001, 1'b1}                                                   // R11
    };

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] insn, input logic [63:0] fs, input logic [63:0] ft,
                          input logic [63:0] fd, input logic [63:0] al, input logic [7:0] cc,
                          input logic be);
        @(negedge clk);
        valid_i = 1'b1; insn_i = insn; fs_i = fs; ft_i = ft; fd_i = fd;
        align_i = al; cc_i = cc; big_endian_i = be;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    // Reference from the requirements text: returns {result, we, ri, unpred}.
    function automatic logic [66:0] model(input logic [31:0] insn, input logic [63:0] fs,
                                          input logic [63:0] ft, input logic [63:0] fd,
                                          input logic [2:0] al, input logic [7:0] cc,
                                          input logic be);
        logic [63:0] r; logic ok; logic up;
        r = 64'h0; ok = 1'b0; up = 1'b0;
        if (insn[31:26] == 6'b010001 && insn[25:21] == 5'b10110) begin
            case (insn[5:0])
                6'b101100: begin r = {fs[31:0], ft[31:0]}; ok = 1; end
                6'b101101: begin r = {fs[31:0], ft[63:32]}; ok = 1; end
                6'b101110: begin r = {fs[63:32], ft[31:0]}; ok = 1; end
                6'b101111: begin r = {fs[63:32], ft[63:32]}; ok = 1; end
                6'b101000: begin r = {32'h0, fs[31:0]}; ok = 1; end
                6'b100000: begin r = {32'h0, fs[63:32]}; ok = 1; end
                6'b010001: if (insn[17] == 1'b0 && insn[20:18] != 3'd7) begin
                    r[63:32] = (cc[insn[20:18]+3'd1] == insn[16]) ? fs[63:32] : fd[63:32];
                    r[31:0]  = (cc[insn[20:18]] == insn[16]) ? fs[31:0] : fd[31:0];
                    ok = 1;
                end
                default: ok = 0;
            endcase
        end else if (insn[31:26] == 6'b010001 && insn[25:21] == 5'b10000 &&
                     insn[5:0] == 6'b100110) begin
            r = {fs[31:0], ft[31:0]}; ok = 1;
        end else if (insn[31:26] == 6'b010011 && insn[5:0] == 6'b011110) begin
            ok = 1;
            if (al[1:0] != 2'b00) begin r = fs; up = 1; end
            else if (!al[2]) r = fs;
            else if (be) r = {fs[31:0], ft[63:32]};
            else r = {ft[31:0], fs[63:32]};
        end
        if (!ok) r = 64'h0;
        return {r, ok, !ok, up};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] ops [10];
        rst = 1'b1; valid_i = 1'b0; insn_i = '0; fs_i = '0; ft_i = '0; fd_i = '0;
        align_i = '0; cc_i = '0; big_endian_i = 1'b0; user_mode_i = 1'b0;
        ux_en_i = 1'b0; px_en_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 result", result_o, 64'h0);
        chk("R1 strobes", {61'h0, wr_en_o, ri_exc_o, unpred_o}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {result_o[0], wr_en_o, ri_exc_o, unpred_o}, 64'h0);

        // Vector table: R2 R3 R4 R5 R6 R7 R9 R11
        for (int i = 0; i < NV; i++) begin
            run_op(VT[i].insn, VT[i].fs, VT[i].ft, VT[i].fd, {61'h0, VT[i].al},
                   VT[i].cc, VT[i].be);
            chk($sformatf("table[%0d] result", i), result_o, VT[i].exp);
            chk($sformatf("table[%0d] we/ri", i), {62'h0, wr_en_o, ri_exc_o},
                {62'h0, VT[i].we, !VT[i].we});
        end

        // R10: idle cycle holds the result and drops strobes
        @(negedge clk);
        chk("R10 hold result", result_o, 64'hFFFFFFFF_00000001);
        chk("R10 idle strobes", {61'h0, wr_en_o, ri_exc_o, unpred_o}, 64'h0);

        // R5: misaligned values give fs and the unpredictable marker
        run_op(mk_aln(), A, B, D, 64'd1, 8'h00, 1'b1);
        chk("R5 misalign1 result", result_o, A);
        chk("R5 misalign1 flags", {62'h0, wr_en_o, unpred_o}, 64'h3);
        run_op(mk_aln(), A, B, D, 64'd6, 8'h00, 1'b0);
        chk("R5 misalign6 result", result_o, A);
        chk("R5 misalign6 flag", {63'h0, unpred_o}, 64'h1);
        run_op(mk_aln(), A, B, D, 64'd4, 8'h00, 1'b0);
        chk("R5 aligned no flag", {63'h0, unpred_o}, 64'h0);

        // R7: upper lane follows cc+1 only
        run_op(mk_mov(3'd2, 1'b1), A, B, D, 64'd0, 8'h08, 1'b0);
        chk("R7 upper only", result_o, 64'h11112222_BBBBCCCC);

        // R8: privilege gate
        user_mode_i = 1'b1;
        run_op(mk_ps(6'b101100), A, B, D, 64'd0, 8'h00, 1'b0);
        chk("R8 trap flags", {62'h0, wr_en_o, ri_exc_o}, 64'h1);
        chk("R8 trap result", result_o, 64'h0);
        ux_en_i = 1'b1;
        run_op(mk_ps(6'b101100), A, B, D, 64'd0, 8'h00, 1'b0);
        chk("R8 ux enables", {62'h0, wr_en_o, ri_exc_o}, 64'h2);
        ux_en_i = 1'b0; px_en_i = 1'b1;
        run_op(mk_aln(), A, B, D, 64'd4, 8'h00, 1'b1);
        chk("R8 px enables", result_o, 64'h33334444_55556666);
        user_mode_i = 1'b0; px_en_i = 1'b0;

        // Random lane data over all operations
        ops = '{mk_ps(6'b101100), mk_ps(6'b101101), mk_ps(6'b101110), mk_ps(6'b101111),
                mk_sgl(6'b100110), mk_ps(6'b101000), mk_ps(6'b100000), mk_aln(),
                mk_mov(3'($urandom_range(0, 6)), 1'b1), mk_mov(3'($urandom_range(0, 6)), 1'b0)};
        for (int n = 0; n < 60; n++) begin
            logic [63:0] rf, rt, rd; logic [2:0] ra; logic [7:0] rc; logic rb;
            logic [66:0] e; logic [31:0] op;
            rf = {$urandom, $urandom}; rt = {$urandom, $urandom}; rd = {$urandom, $urandom};
            ra = 3'($urandom); rc = 8'($urandom); rb = 1'($urandom);
            op = ops[$urandom_range(0, 9)];
            e = model(op, rf, rt, rd, ra, rc, rb);
            run_op(op, rf, rt, rd, {61'h0, ra}, rc, rb);
            chk($sformatf("R2-R7 random[%0d] result", n), result_o, e[66:3]);
            chk($sformatf("R11 random[%0d] flags", n),
                {61'h0, wr_en_o, ri_exc_o, unpred_o}, {61'h0, e[2:0]});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule